// File: doc/BRIEF.md
# Per-Core Timer Register Window Router

This block places up to four identical per-core timer instances behind one register request port. The address space is split into 32-byte windows. Window 0 is an alias: it always reaches the timer of the core that issued the request, using the core number carried with the request. Each following window is tied to one core's timer, so any core can reach any other core's timer by picking that window. The router decodes the window number and the word inside the window. It raises the select of exactly one timer for one cycle and forwards the write flag, word index and write data. It returns the selected timer's read data one cycle later.

Requests use a valid/ready handshake, and so do responses. The requester must hold every request field stable while `req_valid` is high and `req_ready` is low. The router has a single response slot. `req_ready` is high when that slot is empty, or when the response in it is taken in the same cycle. A response stays on `rsp_*`, unchanged, until `rsp_ready` is seen high. An access that is not a full, aligned 32-bit word, or that names a window or core with no timer, never reaches any timer. It is answered with zero data and `rsp_err` set. Each timer's interrupt is passed straight to its own output line, in core order.

Top module: `core_timer_window_router`

## Requirements
- R1: A request to window 0 (address bits above bit 4 all zero) selects the timer whose index equals `req_core`.
- R2: A request to window n+1 selects timer n for every n below `N_CORES`, whatever the value of `req_core`.
- R3: On an accepted valid request, exactly one bit of `tmr_sel` is high for that single cycle. In that cycle `tmr_word` equals address bits [4:2], and `tmr_write` and `tmr_wdata` carry the request. Without an accepted valid request, `tmr_sel` is zero.
- R4: The cycle after acceptance, `rsp_valid` is high. On a valid read, `rsp_rdata` holds the selected timer's word as sampled at acceptance. A valid write returns zero data. `rsp_err` is 0 for a valid access.
- R5: A request whose `req_size` is not 2'b10 (a 32-bit word) raises no select. Its response carries `rsp_err`=1 and zero data. Codes 0, 1 and 3 mean byte, half word and double word.
- R6: A request with address bits [1:0] not zero raises no select. Its response carries `rsp_err`=1 and zero data.
- R7: A request to a window above `N_CORES` raises no select. Its response carries `rsp_err`=1 and zero data.
- R8: A window 0 request with `req_core` at or above `N_CORES` raises no select. Its response carries `rsp_err`=1 and zero data.
- R9: `irq_o[k]` follows `tmr_irq_i[k]` combinationally for every core k.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low, no select is raised, and `rsp_rdata` and `rsp_err` hold their values.
- R11: During and right after reset, `rsp_valid` is low and `req_ready` is high.
- R12: An `N_CORES` outside 1 to 4, or an address width too narrow for `N_CORES`+1 windows, stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address: window number above bit 4, offset in bits [4:0] |
| req_size | input | 2 | Access size code (2'b10 = 32-bit word) |
| req_core | input | 2 | Index of the requesting core |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken this cycle if valid |
| rsp_rdata | output | DATA_W | Read data, zero for writes and errors |
| rsp_err | output | 1 | Access was rejected |
| tmr_sel | output | N_CORES | One-cycle select, one bit per timer |
| tmr_write | output | 1 | Write flag to timers |
| tmr_word | output | 3 | Word index within the window |
| tmr_wdata | output | DATA_W | Write data to timers |
| tmr_rdata | input | N_CORES*DATA_W | Read data from timers, timer k at bits [k*DATA_W +: DATA_W] |
| tmr_irq_i | input | N_CORES | Interrupt from each timer |
| irq_o | output | N_CORES | Interrupt lines out, core order |

## Verification
A wrong target in the decoder shows in the same cycle as a wrong or extra bit on `tmr_sel`. A value written through one window and read back through another then disagrees one cycle after the read is accepted. A response slot whose valid flag or held data goes bad shows up when `rsp_ready` is held low. `req_ready` would rise early, or the held data would change, within the first stalled cycle. Error decoding that lets a rejected request through shows as a select pulse. It also leaves a timer word changed, and a later good read of that word shows the change.

// File: rtl/cwr_pkg.sv
package cwr_pkg;
  localparam int MAX_CORES  = 4;
  localparam int CID_W      = 2;
  localparam int WIN_OFS_W  = 5;   // 32-byte window
  localparam int WORD_IDX_W = WIN_OFS_W - 2;

  typedef enum logic [1:0] {
    ACC_BYTE  = 2'd0,
    ACC_HALF  = 2'd1,
    ACC_WORD  = 2'd2,
    ACC_DWORD = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic                  hit;
    logic [CID_W-1:0]      tgt;
    logic [WORD_IDX_W-1:0] word;
  } route_t;
endpackage

// File: rtl/cwr_window_decode.sv
module cwr_window_decode
  import cwr_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int ADDR_W  = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [CID_W-1:0]  core,
  output route_t            route
);
  localparam int WIN_W = ADDR_W - WIN_OFS_W;

  logic [WIN_W-1:0] win;
  logic size_ok, align_ok, win_ok;

  assign win = addr[ADDR_W-1:WIN_OFS_W];

  always_comb begin
    size_ok    = (size == ACC_WORD);
    align_ok   = (addr[1:0] == 2'b00);
    route.word = addr[WIN_OFS_W-1:2];
    if (win == '0) begin
      // banked alias: steer by requesting core
      route.tgt = core;
      win_ok    = int'(core) < N_CORES;
    end else begin
      // fixed window n+1 -> core n
      route.tgt = CID_W'(win - 1'b1);
      win_ok    = int'(win) <= N_CORES;
    end
    route.hit = size_ok & align_ok & win_ok;
  end
endmodule

// File: rtl/cwr_read_mux.sv
module cwr_read_mux
  import cwr_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int DATA_W  = 32
) (
  input  logic [N_CORES*DATA_W-1:0] rdata_flat,
  input  logic [CID_W-1:0]          idx,
  output logic [DATA_W-1:0]         rdata
);
  always_comb begin
    rdata = '0;
    for (int k = 0; k < N_CORES; k++) begin
      if (idx == CID_W'(k)) rdata = rdata_flat[k*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/cwr_rsp_stage.sv
module cwr_rsp_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_err,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              slot_free
);
  assign slot_free = ~rsp_valid | rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= load_data;
      rsp_err   <= load_err;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/core_timer_window_router.sv
module core_timer_window_router
  import cwr_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [1:0]                req_size,
  input  logic [CID_W-1:0]          req_core,
  input  logic [DATA_W-1:0]         req_wdata,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [DATA_W-1:0]         rsp_rdata,
  output logic                      rsp_err,
  output logic [N_CORES-1:0]        tmr_sel,
  output logic                      tmr_write,
  output logic [WORD_IDX_W-1:0]     tmr_word,
  output logic [DATA_W-1:0]         tmr_wdata,
  input  logic [N_CORES*DATA_W-1:0] tmr_rdata,
  input  logic [N_CORES-1:0]        tmr_irq_i,
  output logic [N_CORES-1:0]        irq_o
);
  localparam int WIN_W    = ADDR_W - WIN_OFS_W;
  localparam int WIN_NEED = $clog2(N_CORES + 1);

  // R12: configuration guard
  if (N_CORES < 1 || N_CORES > MAX_CORES) begin : g_bad_cores
    $error("core_timer_window_router: N_CORES must be 1..%0d", MAX_CORES);
  end
  if (WIN_W < WIN_NEED) begin : g_bad_addr
    $error("core_timer_window_router: ADDR_W too narrow for window count");
  end

  route_t              route;
  logic [DATA_W-1:0]   rd_word;
  logic                slot_free;
  logic                accept;

  cwr_window_decode #(.N_CORES(N_CORES), .ADDR_W(ADDR_W)) u_dec (
    .addr  (req_addr),
    .size  (req_size),
    .core  (req_core),
    .route (route)
  );

  cwr_read_mux #(.N_CORES(N_CORES), .DATA_W(DATA_W)) u_mux (
    .rdata_flat (tmr_rdata),
    .idx        (route.tgt),
    .rdata      (rd_word)
  );

  assign accept    = req_valid & slot_free;
  assign req_ready = slot_free;

  cwr_rsp_stage #(.DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_data ((route.hit & ~req_write) ? rd_word : '0),
    .load_err  (~route.hit),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .slot_free (slot_free)
  );

  assign tmr_write = req_write;
  assign tmr_word  = route.word;
  assign tmr_wdata = req_wdata;

  for (genvar k = 0; k < N_CORES; k++) begin : g_core
    assign tmr_sel[k] = accept & route.hit & (route.tgt == CID_W'(k));
    assign irq_o[k]   = tmr_irq_i[k];
  end
endmodule

// File: rtl/cwr_router_checker.sv
module cwr_router_checker
  import cwr_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic [ADDR_W-1:0]   req_addr,
  input logic [1:0]          req_size,
  input logic [CID_W-1:0]    req_core,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic [DATA_W-1:0]   rsp_rdata,
  input logic                rsp_err,
  input logic [N_CORES-1:0]  tmr_sel,
  input logic [N_CORES-1:0]  tmr_irq_i,
  input logic [N_CORES-1:0]  irq_o
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(tmr_sel)); // R3
  AST_SEL_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (|tmr_sel) |-> (req_valid && req_ready)); // R3
  AST_RSP_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> rsp_valid); // R4
  AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_err) |-> (rsp_rdata == '0)); // R5
  AST_BAD_SIZE_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_size != 2'b10) |-> (tmr_sel == '0)); // R5
  AST_MISALIGN_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_addr[1:0] != 2'b00) |-> (tmr_sel == '0)); // R6
  AST_BAD_WINDOW_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && int'(req_addr[ADDR_W-1:WIN_OFS_W]) > N_CORES) |-> (tmr_sel == '0)); // R7
  AST_BAD_CORE_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_addr[ADDR_W-1:WIN_OFS_W] == '0 && int'(req_core) >= N_CORES) |-> (tmr_sel == '0)); // R8
  AST_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) irq_o == tmr_irq_i); // R9
  AST_STALL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_ready) |-> !req_ready); // R10
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err))); // R10
endmodule

bind core_timer_window_router cwr_router_checker #(
  .N_CORES(N_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_size(req_size), .req_core(req_core),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .rsp_err(rsp_err), .tmr_sel(tmr_sel), .tmr_irq_i(tmr_irq_i), .irq_o(irq_o)
);

// File: tb/core_timer_window_router_test.sv
`timescale 1ns/1ps
module core_timer_window_router_test;
  localparam int NC = 3;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = 2'b10;
  logic [1:0]    req_core = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_err;
  logic [NC-1:0] tmr_sel;
  logic          tmr_write;
  logic [2:0]    tmr_word;
  logic [DW-1:0] tmr_wdata;
  logic [NC*DW-1:0] tmr_rdata;
  logic [NC-1:0] tmr_irq_i = '0;
  logic [NC-1:0] irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] rd;
  logic        er;

  always #2.5 clk = ~clk;

  core_timer_window_router #(.N_CORES(NC), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_core(req_core), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .tmr_sel(tmr_sel), .tmr_write(tmr_write), .tmr_word(tmr_word),
    .tmr_wdata(tmr_wdata), .tmr_rdata(tmr_rdata), .tmr_irq_i(tmr_irq_i),
    .irq_o(irq_o)
  );

  // bench-side timer register model: 8 words per timer
  logic [31:0] tregs [NC][8];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NC; k++)
        for (int i = 0; i < 8; i++)
          tregs[k][i] <= 32'hC000_0000 | (k << 8) | i;
    end else begin
      for (int k = 0; k < NC; k++)
        if (tmr_sel[k] && tmr_write) tregs[k][tmr_word] <= tmr_wdata;
    end
  end
  always_comb begin
    for (int k = 0; k < NC; k++) tmr_rdata[k*DW +: DW] = tregs[k][tmr_word];
  end

  function automatic logic [31:0] init_word(int k, int i);
    return 32'hC000_0000 | (k << 8) | i;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [7:0] a, input logic [31:0] d,
                        input logic [1:0] sz, input logic [1:0] cid,
                        input logic [2:0] exp_sel, input string tag,
                        output logic [31:0] rdat, output logic rerr);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    req_size = sz; req_core = cid;
    #1;
    chk({tag, " select"}, 32'(tmr_sel), 32'(exp_sel));
    if (exp_sel != 3'b000) chk({tag, " word"}, 32'(tmr_word), 32'(a[4:2]));
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    rdat = rsp_rdata;
    rerr = rsp_err;
  endtask

  task automatic t_reset;
    chk("R11 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    chk("R11 req_ready in reset", 32'(req_ready), 32'd1);
    chk("R3 no select idle", 32'(tmr_sel), 32'd0);
  endtask

  task automatic t_alias;
    access(1'b1, 8'h08, 32'hA5A5_0001, 2'b10, 2'd2, 3'b100, "R1 alias write core2", rd, er);
    chk("R4 write err", 32'(er), 32'd0);
    chk("R4 write data zero", rd, 32'd0);
    access(1'b0, 8'h68, 32'd0, 2'b10, 2'd0, 3'b100, "R2 window3 read", rd, er);
    chk("R2 window3 data", rd, 32'hA5A5_0001);
    chk("R4 read err", 32'(er), 32'd0);
  endtask

  task automatic t_fixed;
    access(1'b1, 8'h44, 32'h0B0B_0002, 2'b10, 2'd0, 3'b010, "R2 window2 write", rd, er);
    access(1'b0, 8'h04, 32'd0, 2'b10, 2'd1, 3'b010, "R1 alias read core1", rd, er);
    chk("R1 alias data core1", rd, 32'h0B0B_0002);
    access(1'b0, 8'h2C, 32'd0, 2'b10, 2'd2, 3'b001, "R2 window1 read", rd, er);
    chk("R2 window1 data", rd, init_word(0, 3));
  endtask

  task automatic t_size;
    access(1'b0, 8'h00, 32'd0, 2'b00, 2'd0, 3'b000, "R5 byte read", rd, er);
    chk("R5 byte err", 32'(er), 32'd1);
    chk("R5 byte data", rd, 32'd0);
    access(1'b1, 8'h20, 32'hDEAD_BEEF, 2'b01, 2'd2, 3'b000, "R5 half write", rd, er);
    chk("R5 half err", 32'(er), 32'd1);
    access(1'b0, 8'h20, 32'd0, 2'b10, 2'd2, 3'b001, "R5 readback", rd, er);
    chk("R5 half write dropped", rd, init_word(0, 0));
  endtask

  task automatic t_align;
    access(1'b0, 8'h22, 32'd0, 2'b10, 2'd0, 3'b000, "R6 misaligned read", rd, er);
    chk("R6 misaligned err", 32'(er), 32'd1);
    access(1'b1, 8'h41, 32'h1111_2222, 2'b10, 2'd0, 3'b000, "R6 misaligned write", rd, er);
    access(1'b0, 8'h40, 32'd0, 2'b10, 2'd0, 3'b010, "R6 readback", rd, er);
    chk("R6 misaligned write dropped", rd, init_word(1, 0));
  endtask

  task automatic t_window;
    access(1'b0, 8'h80, 32'd0, 2'b10, 2'd0, 3'b000, "R7 window4 read", rd, er);
    chk("R7 window4 err", 32'(er), 32'd1);
    chk("R7 window4 data", rd, 32'd0);
    access(1'b1, 8'h84, 32'h3333_4444, 2'b10, 2'd0, 3'b000, "R7 window4 write", rd, er);
    chk("R7 window4 write err", 32'(er), 32'd1);
    access(1'b0, 8'hE0, 32'd0, 2'b10, 2'd1, 3'b000, "R7 window7 read", rd, er);
    chk("R7 window7 err", 32'(er), 32'd1);
  endtask

  task automatic t_core;
    access(1'b0, 8'h00, 32'd0, 2'b10, 2'd3, 3'b000, "R8 core3 read", rd, er);
    chk("R8 core3 err", 32'(er), 32'd1);
    access(1'b1, 8'h0C, 32'h5555_6666, 2'b10, 2'd3, 3'b000, "R8 core3 write", rd, er);
    chk("R8 core3 write err", 32'(er), 32'd1);
    access(1'b0, 8'h0C, 32'd0, 2'b10, 2'd2, 3'b100, "R8 readback", rd, er);
    chk("R8 core3 write dropped", rd, init_word(2, 3));
  endtask

  task automatic t_irq;
    @(negedge clk);
    tmr_irq_i = 3'b101; #1;
    chk("R9 irq 101", 32'(irq_o), 32'b101);
    tmr_irq_i = 3'b010; #1;
    chk("R9 irq 010", 32'(irq_o), 32'b010);
    tmr_irq_i = 3'b000;
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h68; req_size = 2'b10; req_core = 2'd0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 first rsp valid", 32'(rsp_valid), 32'd1);
    chk("R10 first rsp data", rsp_rdata, 32'hA5A5_0001);
    chk("R10 not ready when full", 32'(req_ready), 32'd0);
    req_addr = 8'h04; req_core = 2'd0; #1;
    chk("R10 no select while stalled", 32'(tmr_sel), 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R10 data held", rsp_rdata, 32'hA5A5_0001);
    chk("R10 valid held", 32'(rsp_valid), 32'd1);
    rsp_ready = 1'b1; #1;
    chk("R10 ready on drain", 32'(req_ready), 32'd1);
    chk("R10 select on drain", 32'(tmr_sel), 32'b001);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 second rsp data", rsp_rdata, init_word(0, 1));
    @(posedge clk);
    @(negedge clk);
    chk("R10 slot empties", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    t_alias();
    t_fixed();
    t_size();
    t_align();
    t_window();
    t_core();
    t_irq();
    t_backpressure();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule